// File: doc/BRIEF.md
# Instruction Skip Decision Unit

This block sits next to the decode stage of a small 8-bit microcontroller core. For each accepted instruction it decides how many of the following instructions must be turned into no-ops. The answer is 0, 1 or 2. It handles the conditional-skip family: single-bit tests on a file register, and decrement or increment of a file register followed by a test for zero. It also handles two extra instructions. One skips two slots when the bitwise AND of the two port output registers is zero. The other increments a register and skips one slot when the new value equals the port C output register.

The decision is registered. A count loaded in cycle N appears on `skip_cnt` in cycle N+1, and the fetch and program-counter logic turns it into no-op slots. The unit also keeps its own record of pending squashes. The next `skip_cnt` valid instructions after a skipping one are treated as squashed, and they produce no skip of their own.

The instruction input is a plain valid strobe with no ready signal. The unit takes one instruction in every cycle that `instr_valid` is high and never applies back-pressure. Cycles with the strobe low are ignored: they neither produce a skip nor use up a pending squash.

Top module: `skip_unit`

## Requirements
- R1: Bit-test-skip-if-clear has `instr[13:10]=4'b0110`. `instr[9:7]` selects a bit of `file_operand`. The count is 1 when that bit is 0, and 0 otherwise.
- R2: Bit-test-skip-if-set has `instr[13:10]=4'b0111`, with the same bit select. The count is 1 when the selected bit is 1, and 0 otherwise.
- R3: Decrement-skip-if-zero has `instr[13:8]=6'b001011`. The count is 1 when `file_operand-1` (8-bit, 0x00 wraps to 0xFF) is zero, so only an operand of 0x01 skips.
- R4: Increment-skip-if-zero has `instr[13:8]=6'b001111`. The count is 1 when `file_operand+1` (8-bit, 0xFF wraps to 0x00) is zero.
- R5: The port-AND skip is the exact code `14'h0003`. The count is 2 when `(portb_val & portc_val)==0`, and 0 otherwise. No count ever exceeds 2.
- R6: Increment-compare-port-C has `instr[13:8]=6'b110100`. The count is 1 when `file_operand+1` (8-bit, with wrap) equals `portc_val`.
- R7: Every other instruction code gives a count of 0. This includes `14'h0000`, `14'h0002` and literal or control codes.
- R8: `skip_cnt` is registered. It shows the decision for an instruction accepted on the previous clock edge, and it is 0 after any cycle with `instr_valid` low.
- R9: After a non-zero count N, the next N valid instructions are squashed and each yields count 0. Invalid cycles in between do not use up the squash.
- R10: While `rst_n` is low, `skip_cnt` is 0 and any pending squash is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction strobe; instruction accepted in every cycle it is high |
| instr | input | 14 | Current instruction word |
| file_operand | input | 8 | Value read from the addressed file register |
| portb_val | input | 8 | Port B output register |
| portc_val | input | 8 | Port C output register |
| skip_cnt | output | 2 | Number of following slots to squash (0, 1 or 2) |

## Verification
On every cycle the assertions check that the count stays in range and is zero after an idle cycle. They also check that a valid instruction arriving while a squash is pending gives a zero count, that a loaded count and the pending-squash counter agree, and that the decoded instruction classes never overlap. The per-instruction conditions are shown only by the bench's scenarios: bit selection, the wrap at 0x00 and 0xFF, the port AND and the port-C equality. The same holds for squashes spread across idle gaps and for a reset that cancels a pending squash.

// File: rtl/skip_pkg.sv
package skip_pkg;

  localparam int unsigned INSTR_W = 14;

  // Opcode prefixes used by the classifier
  localparam logic [3:0]  OPC_BIT_CLR  = 4'b0110;   // instr[13:10]
  localparam logic [3:0]  OPC_BIT_SET  = 4'b0111;   // instr[13:10]
  localparam logic [5:0]  OPC_DEC_Z    = 6'b001011; // instr[13:8]
  localparam logic [5:0]  OPC_INC_Z    = 6'b001111; // instr[13:8]
  localparam logic [5:0]  OPC_INC_EQC  = 6'b110100; // instr[13:8]
  localparam logic [13:0] OPC_PORT_AND = 14'h0003;  // exact match

  typedef struct packed {
    logic bit_clr;
    logic bit_set;
    logic dec_z;
    logic inc_z;
    logic port_and;
    logic inc_eqc;
  } skip_class_t;

endpackage

// File: rtl/skip_classify.sv
module skip_classify
  import skip_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SEL_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr,
  output skip_class_t        cls,
  output logic [SEL_W-1:0]   bit_sel
);

  logic [3:0] top4;
  logic [5:0] top6;

  assign top4 = instr[13:10];
  assign top6 = instr[13:8];

  always_comb begin
    cls          = '0;
    cls.bit_clr  = (top4 == OPC_BIT_CLR);
    cls.bit_set  = (top4 == OPC_BIT_SET);
    cls.dec_z    = (top6 == OPC_DEC_Z);
    cls.inc_z    = (top6 == OPC_INC_Z);
    cls.inc_eqc  = (top6 == OPC_INC_EQC);
    cls.port_and = (instr == OPC_PORT_AND);
  end

  // Bit position field sits just above the 7-bit register address
  assign bit_sel = instr[7 +: SEL_W];

  // Decoded classes are mutually exclusive (supports R7: one decision per word)
  p_class_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cls));

endmodule

// File: rtl/skip_evaluate.sv
module skip_evaluate
  import skip_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAX_SKIP = 2,
  localparam int unsigned SEL_W   = $clog2(DATA_W),
  localparam int unsigned CNT_W   = $clog2(MAX_SKIP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  skip_class_t       cls,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] port_b,
  input  logic [DATA_W-1:0] port_c,
  output logic [CNT_W-1:0]  decision
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] dec_val;
  logic [DATA_W-1:0] inc_val;
  logic [DATA_W-1:0] port_mix;
  logic              sel_bit;
  logic              cond_single;
  logic              cond_double;

  // Wrapping modular arithmetic on the operand
  assign dec_val  = operand - ONE;
  assign inc_val  = operand + ONE;
  assign port_mix = port_b & port_c;

  // Bit multiplexer built per position
  logic [DATA_W-1:0] bit_hit;
  generate
    for (genvar g = 0; g < DATA_W; g++) begin : g_bitmux
      assign bit_hit[g] = (bit_sel == SEL_W'(g)) & operand[g];
    end
  endgenerate
  assign sel_bit = |bit_hit;

  always_comb begin
    cond_single = 1'b0;
    if (cls.bit_clr) cond_single = ~sel_bit;
    if (cls.bit_set) cond_single = sel_bit;
    if (cls.dec_z)   cond_single = (dec_val == '0);
    if (cls.inc_z)   cond_single = (inc_val == '0);
    if (cls.inc_eqc) cond_single = (inc_val == port_c);
  end

  assign cond_double = cls.port_and & (port_mix == '0);

  always_comb begin
    decision = '0;
    if (cond_double)      decision = CNT_W'(MAX_SKIP);
    else if (cond_single) decision = CNT_W'(1);
  end

  // A two-slot decision only comes from the port-AND instruction (R5)
  p_double_only_portand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (decision == CNT_W'(MAX_SKIP)) |-> cls.port_and);

endmodule

// File: rtl/skip_squash_ctrl.sv
module skip_squash_ctrl #(
  parameter int unsigned MAX_SKIP = 2,
  localparam int unsigned CNT_W   = $clog2(MAX_SKIP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [CNT_W-1:0] decision,
  output logic             accept,
  output logic [CNT_W-1:0] pending
);

  logic [CNT_W-1:0] pending_q;

  assign accept  = valid && (pending_q == '0);
  assign pending = pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= '0;
    end else if (valid) begin
      if (pending_q != '0) pending_q <= pending_q - CNT_W'(1);
      else                 pending_q <= decision;
    end
  end

  // Idle cycles leave the pending squash untouched (R9)
  p_idle_keeps_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(pending_q));

  p_pending_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q <= CNT_W'(MAX_SKIP));

endmodule

// File: rtl/skip_unit.sv
module skip_unit
  import skip_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAX_SKIP = 2,
  localparam int unsigned SEL_W   = $clog2(DATA_W),
  localparam int unsigned CNT_W   = $clog2(MAX_SKIP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  file_operand,
  input  logic [DATA_W-1:0]  portb_val,
  input  logic [DATA_W-1:0]  portc_val,
  output logic [CNT_W-1:0]   skip_cnt
);

  skip_class_t      cls;
  logic [SEL_W-1:0] bit_sel;
  logic [CNT_W-1:0] decision;
  logic             accept;
  logic [CNT_W-1:0] pending;
  logic [CNT_W-1:0] skip_q;

  skip_classify #(.DATA_W(DATA_W)) u_classify (
    .clk     (clk),
    .rst_n   (rst_n),
    .instr   (instr),
    .cls     (cls),
    .bit_sel (bit_sel)
  );

  skip_evaluate #(.DATA_W(DATA_W), .MAX_SKIP(MAX_SKIP)) u_evaluate (
    .clk      (clk),
    .rst_n    (rst_n),
    .cls      (cls),
    .bit_sel  (bit_sel),
    .operand  (file_operand),
    .port_b   (portb_val),
    .port_c   (portc_val),
    .decision (decision)
  );

  skip_squash_ctrl #(.MAX_SKIP(MAX_SKIP)) u_squash (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (instr_valid),
    .decision (decision),
    .accept   (accept),
    .pending  (pending)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      skip_q <= '0;
    else if (accept) skip_q <= decision;
    else             skip_q <= '0;
  end

  assign skip_cnt = skip_q;

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q <= CNT_W'(MAX_SKIP));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (skip_q == '0));

  p_squashed_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && pending != '0) |=> (skip_q == '0));

  p_count_matches_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q != '0) |-> (pending == skip_q));

endmodule

// File: tb/skip_unit_tb.sv
module skip_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [13:0] instr = '0;
  logic [7:0]  file_operand = '0;
  logic [7:0]  portb_val = '0;
  logic [7:0]  portc_val = '0;
  logic [1:0]  skip_cnt;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skip_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr        (instr),
    .file_operand (file_operand),
    .portb_val    (portb_val),
    .portc_val    (portc_val),
    .skip_cnt     (skip_cnt)
  );

  typedef struct packed {
    logic [13:0] ins;
    logic [7:0]  op;
    logic [7:0]  pb;
    logic [7:0]  pc;
    logic [1:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{14'h1985, 8'hF7, 8'h00, 8'h00, 2'd1, 4'd1},  // R1 bit3 clear
    '{14'h1985, 8'h08, 8'h00, 8'h00, 2'd0, 4'd1},  // R1 bit3 set
    '{14'h1F80, 8'h80, 8'h00, 8'h00, 2'd1, 4'd2},  // R2 bit7 set
    '{14'h1C01, 8'hFE, 8'h00, 8'h00, 2'd0, 4'd2},  // R2 bit0 clear
    '{14'h0B20, 8'h01, 8'h00, 8'h00, 2'd1, 4'd3},  // R3 1 -> 0
    '{14'h0B20, 8'h00, 8'h00, 8'h00, 2'd0, 4'd3},  // R3 0 wraps to FF
    '{14'h0FA0, 8'hFF, 8'h00, 8'h00, 2'd1, 4'd4},  // R4 FF wraps to 0
    '{14'h0FA0, 8'h7F, 8'h00, 8'h00, 2'd0, 4'd4},  // R4 no zero
    '{14'h0003, 8'h00, 8'hF0, 8'h0F, 2'd2, 4'd5},  // R5 AND zero
    '{14'h0003, 8'h00, 8'h11, 8'h10, 2'd0, 4'd5},  // R5 AND non-zero
    '{14'h3412, 8'h41, 8'h00, 8'h42, 2'd1, 4'd6},  // R6 equal
    '{14'h3412, 8'hFF, 8'h00, 8'h00, 2'd1, 4'd6},  // R6 wrap equal
    '{14'h3412, 8'h41, 8'h00, 8'h41, 2'd0, 4'd6},  // R6 unequal
    '{14'h0000, 8'h00, 8'h00, 8'h00, 2'd0, 4'd7},  // R7 no-op code
    '{14'h0002, 8'h00, 8'h00, 8'h00, 2'd0, 4'd7},  // R7 near miss
    '{14'h2003, 8'h01, 8'h00, 8'h00, 2'd0, 4'd7},  // R7 call code
    '{14'h3E00, 8'hFF, 8'h00, 8'h00, 2'd0, 4'd7}   // R7 literal add
  };

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: skip_cnt=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // Drive one cycle at the falling edge, sample just after the next rising edge
  task automatic step(input logic v, input logic [13:0] i, input logic [7:0] op,
                      input logic [7:0] pb, input logic [7:0] pc);
    @(negedge clk);
    instr_valid  = v;
    instr        = i;
    file_operand = op;
    portb_val    = pb;
    portc_val    = pc;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10: reset state, even with a skip-worthy valid instruction
    step(1'b1, 14'h0003, 8'h00, 8'h00, 8'h00);
    check("R10 reset holds zero", skip_cnt, 2'd0);
    step(1'b0, 14'h0000, 8'h00, 8'h00, 8'h00);
    rst_n = 1'b1;

    // Table walk; each vector is followed by two valid no-ops that drain squash
    for (int k = 0; k < NVEC; k++) begin
      step(1'b1, VECS[k].ins, VECS[k].op, VECS[k].pb, VECS[k].pc);
      check($sformatf("R%0d vector %0d", VECS[k].req, k), skip_cnt, VECS[k].exp);
      step(1'b1, 14'h0000, 8'h00, 8'h00, 8'h00);
      check("R9 drain slot 1", skip_cnt, 2'd0);
      step(1'b1, 14'h0000, 8'h00, 8'h00, 8'h00);
      check("R9 drain slot 2", skip_cnt, 2'd0);
    end

    // R8: skip-worthy inputs with the strobe low give zero
    step(1'b0, 14'h0003, 8'h00, 8'h00, 8'h00);
    check("R8 idle gives zero", skip_cnt, 2'd0);
    // R8: output follows the accepted instruction on the next edge only
    step(1'b1, 14'h0FA0, 8'hFF, 8'h00, 8'h00);
    check("R8 registered count", skip_cnt, 2'd1);
    step(1'b0, 14'h0FA0, 8'hFF, 8'h00, 8'h00);
    check("R8 cleared after idle", skip_cnt, 2'd0);
    // pending squash of 1 now consumed by next valid one
    step(1'b1, 14'h1F80, 8'h80, 8'h00, 8'h00);
    check("R9 squash survives idle gap", skip_cnt, 2'd0);
    step(1'b1, 14'h1F80, 8'h80, 8'h00, 8'h00);
    check("R9 squash used up", skip_cnt, 2'd1);
    step(1'b1, 14'h0000, 8'h00, 8'h00, 8'h00);

    // R9: two-slot squash across idle cycles
    step(1'b1, 14'h0003, 8'h00, 8'h00, 8'h00);
    check("R5 port AND skip two", skip_cnt, 2'd2);
    step(1'b0, 14'h0000, 8'h00, 8'h00, 8'h00);
    step(1'b1, 14'h0B20, 8'h01, 8'h00, 8'h00);
    check("R9 first squashed", skip_cnt, 2'd0);
    step(1'b0, 14'h0000, 8'h00, 8'h00, 8'h00);
    step(1'b1, 14'h0003, 8'h00, 8'h00, 8'h00);
    check("R9 second squashed", skip_cnt, 2'd0);
    step(1'b1, 14'h1985, 8'h00, 8'h00, 8'h00);
    check("R9 third acts", skip_cnt, 2'd1);

    // R10: reset cancels the pending squash
    @(negedge clk);
    rst_n = 1'b0;
    step(1'b0, 14'h0000, 8'h00, 8'h00, 8'h00);
    check("R10 zero in reset", skip_cnt, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 14'h3412, 8'h10, 8'h00, 8'h11);
    check("R10 squash cleared by reset", skip_cnt, 2'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule